// File: doc/BRIEF.md
# Serial Register Access Slave with Time Snapshot

This block is the serial-side front end of a real-time-clock style register bank. An external master selects it with an active-high chip select, clocks it with a serial clock that idles low, and sends a command byte first. The command byte names a starting register among sixteen and one of four transfer kinds: single read, single write, burst read or burst write. Further bytes in the same chip-select window carry the data. In burst mode the address steps up after every data byte and wraps from 15 back to 0.

Registers 0 to 6 hold the time of day and date and belong to a counter outside this block. Reads of these seven are served from a snapshot, which is taken when the command byte completes. A burst read therefore returns one consistent set even if a carry ripples through the counter mid-transfer. Writes to these seven are collected in a staging buffer. They are handed to the counter as one load pulse, with a byte mask, after chip select is released. The counter also clears its sub-second prescaler on that pulse. Registers 7 to 15 live in an ordinary register file and are written through a one-cycle strobe. They are read through a combinational read port addressed by the block. The serial inputs are oversampled by the system clock, which must run at least ten times faster than the serial clock.

Top module: `spi_regs_slave`

## Requirements
- R1: The first byte of a window is the command. Bits 7:4 give the start address. Bit 3 selects single (1) or burst (0), and bit 2 selects read (1) or write (0), so 0x8 is a single write, 0xC a single read, 0x0 a burst write and 0x4 a burst read. Bits 1:0 are ignored.
- R2: Chip select is active high and the serial clock idles low. Bytes move most significant bit first. MOSI is sampled on the falling clock edge, and MISO changes after the rising edge.
- R3: A single access transfers exactly one data byte. Any later byte in the same window writes nothing, and on a read it returns 0x00.
- R4: A burst access steps the address by one after each data byte, wrapping from 15 to 0.
- R5: A data byte written to an address of 7 or more produces exactly one `reg_wr` pulse of one cycle, while chip select is active. During the pulse, `reg_addr` is the target address and `reg_wdata` is the byte.
- R6: Reads of addresses 0 to 6 return the values on `time_in` (byte n at bits 8n+7:8n) as they were when the command byte completed. Later changes on `time_in` do not alter the returned bytes.
- R7: Writes to addresses 0 to 6 do not reach the counter while chip select is active. After chip select falls, `time_load` pulses for one cycle. With it, `time_wdata` carries the written bytes at their positions, and `time_wmask` has bit n set for every address n written. There is no pulse if no time register was written.
- R8: Dropping chip select in the middle of a byte discards that byte. The next window starts again with a command byte.
- R9: MISO is low whenever chip select is inactive, during the command byte, and during writes.
- R10: After reset, `spi_miso`, `reg_wr` and `time_load` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs | input | 1 | Chip select, active high |
| spi_sclk | input | 1 | Serial clock, idle low |
| spi_mosi | input | 1 | Serial data from master |
| spi_miso | output | 1 | Serial data to master |
| reg_addr | output | 4 | Register file address (read port, or write target during `reg_wr`) |
| reg_wdata | output | 8 | Register file write data |
| reg_wr | output | 1 | Register file write strobe |
| reg_rdata | input | 8 | Register file read data for `reg_addr` |
| time_in | input | 56 | Current time registers 0..6, byte n at bits 8n+7:8n |
| time_load | output | 1 | One-cycle load pulse toward the time counter |
| time_wdata | output | 56 | Staged time bytes, byte n at bits 8n+7:8n |
| time_wmask | output | 7 | Bit n set when time register n is loaded |

## Verification
Single write/read pairs at several addresses are used with bit patterns that tell a bit-order or shift-count error apart from a correct transfer: alternating patterns, all ones, all zeros and a lone low bit. Burst reads from address 0 change `time_in` right after the command byte, so a live read is told apart from the snapshot. Other bursts cross the 6-to-7 boundary and the 15-to-0 wrap, which exercises both data sources and the increment. Aborted windows, extra bytes after a single access, and a command with its two low bits set show that partial or surplus data leaves the registers untouched and that the don't-care bits really are ignored.

// File: rtl/spi_regs_pkg.sv
package spi_regs_pkg;

   // Transfer kind, encoded as {single, read} from the command byte.
   typedef enum logic [1:0] {
      XF_BURST_WR  = 2'b00,
      XF_BURST_RD  = 2'b01,
      XF_SINGLE_WR = 2'b10,
      XF_SINGLE_RD = 2'b11
   } xfer_mode_e;

   function automatic xfer_mode_e decode_mode(input logic [1:0] sel);
      return xfer_mode_e'(sel);
   endfunction

   function automatic logic mode_is_read(input xfer_mode_e m);
      return (m == XF_BURST_RD) || (m == XF_SINGLE_RD);
   endfunction

   function automatic logic mode_is_single(input xfer_mode_e m);
      return (m == XF_SINGLE_WR) || (m == XF_SINGLE_RD);
   endfunction

endpackage

// File: rtl/spi_slv_sync.sv
module spi_slv_sync #(
   parameter int WIDTH  = 3,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("spi_slv_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] pipe [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) pipe[s] <= '0;
      end else begin
         pipe[0] <= din;
         for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
      end
   end

   assign dout = pipe[STAGES-1];

endmodule

// File: rtl/spi_slv_shift.sv
module spi_slv_shift #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active,
   input  logic              sclk_rise,
   input  logic              sclk_fall,
   input  logic              mosi,
   input  logic              tx_en,
   input  logic [DATA_W-1:0] tx_data,
   output logic              byte_done,
   output logic [DATA_W-1:0] rx_byte,
   output logic              miso_q
);

   localparam int CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("spi_slv_shift: DATA_W must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0]  bit_cnt;
   logic [DATA_W-1:0] rx_sh;
   logic [DATA_W-1:0] tx_sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt   <= '0;
         rx_sh     <= '0;
         tx_sh     <= '0;
         rx_byte   <= '0;
         byte_done <= 1'b0;
         miso_q    <= 1'b0;
      end else begin
         byte_done <= 1'b0;
         if (!active) begin
            bit_cnt <= '0;
            miso_q  <= 1'b0;
         end else begin
            // sample edge
            if (sclk_fall) begin
               rx_sh <= {rx_sh[DATA_W-2:0], mosi};
               if (bit_cnt == LAST_BIT) begin
                  bit_cnt   <= '0;
                  byte_done <= 1'b1;
                  rx_byte   <= {rx_sh[DATA_W-2:0], mosi};
               end else begin
                  bit_cnt <= bit_cnt + 1'b1;
               end
            end
            // shift edge: first rising edge of a byte loads new data
            if (sclk_rise) begin
               if (bit_cnt == '0) begin
                  miso_q <= tx_en & tx_data[DATA_W-1];
                  tx_sh  <= {tx_data[DATA_W-2:0], 1'b0};
               end else begin
                  miso_q <= tx_en & tx_sh[DATA_W-1];
                  tx_sh  <= {tx_sh[DATA_W-2:0], 1'b0};
               end
            end
         end
      end
   end

endmodule

// File: rtl/spi_slv_time_stage.sv
module spi_slv_time_stage #(
   parameter int DATA_W = 8,
   parameter int NREG   = 7,
   parameter int IDX_W  = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   snap_take,
   input  logic [NREG*DATA_W-1:0] time_in,
   input  logic [IDX_W-1:0]       rd_idx,
   output logic [DATA_W-1:0]      rd_data,
   input  logic                   wr_en,
   input  logic [IDX_W-1:0]       wr_idx,
   input  logic [DATA_W-1:0]      wr_data,
   input  logic                   commit,
   output logic                   load,
   output logic [NREG*DATA_W-1:0] load_data,
   output logic [NREG-1:0]        load_mask
);

   localparam int FLAT_W = NREG * DATA_W;

   generate
      if (NREG < 1 || NREG > (1 << IDX_W)) begin : g_bad_nreg
         $error("spi_slv_time_stage: NREG must fit the index range");
      end
   endgenerate

   logic [FLAT_W-1:0] snap_q, snap_nxt;
   logic [FLAT_W-1:0] stage_q, stage_nxt;
   logic [NREG-1:0]   pend_q, pend_nxt;
   logic [DATA_W-1:0] snap_arr [NREG];

   genvar g;
   generate
      for (g = 0; g < NREG; g++) begin : g_slot
         logic hit;
         assign hit = wr_en && (wr_idx == IDX_W'(g));
         assign snap_nxt[g*DATA_W +: DATA_W]  = snap_take ? time_in[g*DATA_W +: DATA_W]
                                                          : snap_q[g*DATA_W +: DATA_W];
         assign stage_nxt[g*DATA_W +: DATA_W] = hit ? wr_data : stage_q[g*DATA_W +: DATA_W];
         assign pend_nxt[g]                   = pend_q[g] | hit;
         assign snap_arr[g]                   = snap_q[g*DATA_W +: DATA_W];
      end
   endgenerate

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < NREG; i++) begin
         if (rd_idx == IDX_W'(i)) rd_data = snap_arr[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         snap_q    <= '0;
         stage_q   <= '0;
         pend_q    <= '0;
         load      <= 1'b0;
         load_data <= '0;
         load_mask <= '0;
      end else begin
         snap_q  <= snap_nxt;
         stage_q <= stage_nxt;
         load    <= 1'b0;
         if (commit && (pend_q != '0)) begin
            load      <= 1'b1;
            load_data <= stage_q;
            load_mask <= pend_q;
            pend_q    <= '0;
         end else begin
            pend_q <= pend_nxt;
         end
      end
   end

endmodule

// File: rtl/spi_regs_slave.sv
module spi_regs_slave
   import spi_regs_pkg::*;
#(
   parameter int ADDR_W      = 4,
   parameter int DATA_W      = 8,
   parameter int TIME_REGS   = 7,
   parameter int SYNC_STAGES = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        spi_cs,
   input  logic                        spi_sclk,
   input  logic                        spi_mosi,
   output logic                        spi_miso,
   output logic [ADDR_W-1:0]           reg_addr,
   output logic [DATA_W-1:0]           reg_wdata,
   output logic                        reg_wr,
   input  logic [DATA_W-1:0]           reg_rdata,
   input  logic [TIME_REGS*DATA_W-1:0] time_in,
   output logic                        time_load,
   output logic [TIME_REGS*DATA_W-1:0] time_wdata,
   output logic [TIME_REGS-1:0]        time_wmask
);

   localparam int MODE_HI = DATA_W - ADDR_W - 1;

   generate
      if (DATA_W - ADDR_W < 2) begin : g_bad_cmd
         $error("spi_regs_slave: command byte needs two mode bits below the address");
      end
      if (TIME_REGS < 1 || TIME_REGS > (1 << ADDR_W)) begin : g_bad_time
         $error("spi_regs_slave: TIME_REGS must fit the address range");
      end
   endgenerate

   // serial line oversampling
   logic s_cs, s_sclk, s_mosi;
   logic sclk_d, cs_d;

   spi_slv_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  ({spi_cs, spi_sclk, spi_mosi}),
      .dout ({s_cs, s_sclk, s_mosi})
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d <= 1'b0;
         cs_d   <= 1'b0;
      end else begin
         sclk_d <= s_sclk;
         cs_d   <= s_cs;
      end
   end

   logic sclk_rise, sclk_fall, cs_fall;
   assign sclk_rise = s_cs & s_sclk & ~sclk_d;
   assign sclk_fall = s_cs & ~s_sclk & sclk_d;
   assign cs_fall   = cs_d & ~s_cs;

   // transfer control state
   logic              cmd_seen, single_q, read_q, spent_q;
   logic [ADDR_W-1:0] addr_q, wr_addr_q;
   logic              byte_done, miso_q;
   logic [DATA_W-1:0] rx_byte, tx_data, snap_rd;
   logic              data_phase, is_time_addr, tx_en, wr_time;
   xfer_mode_e        cmd_mode;

   assign cmd_mode     = decode_mode(rx_byte[MODE_HI -: 2]);
   assign data_phase   = cmd_seen & ~spent_q;
   assign is_time_addr = int'(addr_q) < TIME_REGS;
   assign tx_en        = data_phase & read_q;
   assign tx_data      = is_time_addr ? snap_rd : reg_rdata;
   assign wr_time      = byte_done & data_phase & ~read_q & is_time_addr;

   spi_slv_shift #(.DATA_W(DATA_W)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .active   (s_cs),
      .sclk_rise(sclk_rise),
      .sclk_fall(sclk_fall),
      .mosi     (s_mosi),
      .tx_en    (tx_en),
      .tx_data  (tx_data),
      .byte_done(byte_done),
      .rx_byte  (rx_byte),
      .miso_q   (miso_q)
   );

   spi_slv_time_stage #(.DATA_W(DATA_W), .NREG(TIME_REGS), .IDX_W(ADDR_W)) u_time (
      .clk      (clk),
      .rst_n    (rst_n),
      .snap_take(byte_done & ~cmd_seen),
      .time_in  (time_in),
      .rd_idx   (addr_q),
      .rd_data  (snap_rd),
      .wr_en    (wr_time),
      .wr_idx   (addr_q),
      .wr_data  (rx_byte),
      .commit   (cs_fall),
      .load     (time_load),
      .load_data(time_wdata),
      .load_mask(time_wmask)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_seen  <= 1'b0;
         single_q  <= 1'b0;
         read_q    <= 1'b0;
         spent_q   <= 1'b0;
         addr_q    <= '0;
         wr_addr_q <= '0;
         reg_wr    <= 1'b0;
         reg_wdata <= '0;
      end else begin
         reg_wr <= 1'b0;
         if (!s_cs) begin
            cmd_seen <= 1'b0;
            spent_q  <= 1'b0;
         end else if (byte_done) begin
            if (!cmd_seen) begin
               cmd_seen <= 1'b1;
               addr_q   <= rx_byte[DATA_W-1 -: ADDR_W];
               single_q <= mode_is_single(cmd_mode);
               read_q   <= mode_is_read(cmd_mode);
            end else if (!spent_q) begin
               if (!read_q && !is_time_addr) begin
                  reg_wr    <= 1'b1;
                  reg_wdata <= rx_byte;
                  wr_addr_q <= addr_q;
               end
               if (single_q) spent_q <= 1'b1;
               else          addr_q  <= addr_q + 1'b1;
            end
         end
      end
   end

   assign reg_addr = reg_wr ? wr_addr_q : addr_q;
   assign spi_miso = miso_q & spi_cs;

endmodule

// File: rtl/spi_regs_slave_chk.sv
module spi_regs_slave_chk #(
   parameter int ADDR_W    = 4,
   parameter int TIME_REGS = 7
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 spi_cs,
   input logic                 cs_s,
   input logic                 cmd_seen,
   input logic                 read_q,
   input logic                 spi_miso,
   input logic                 reg_wr,
   input logic [ADDR_W-1:0]    reg_addr,
   input logic                 time_load,
   input logic [TIME_REGS-1:0] time_wmask
);

   p_wr_single_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr |=> !reg_wr);

   p_wr_addr_upper_r5: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr |-> (int'(reg_addr) >= TIME_REGS));

   p_wr_in_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr |-> $past(cs_s));

   p_load_single_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      time_load |=> !time_load);

   p_load_after_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
      time_load |-> !$past(cs_s));

   p_load_has_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
      time_load |-> (time_wmask != '0));

   p_miso_quiet_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (spi_cs && cmd_seen && !read_q) |-> !spi_miso);

   p_miso_quiet_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_s |=> !spi_miso);

endmodule

bind spi_regs_slave spi_regs_slave_chk #(
   .ADDR_W   (ADDR_W),
   .TIME_REGS(TIME_REGS)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .spi_cs    (spi_cs),
   .cs_s      (s_cs),
   .cmd_seen  (cmd_seen),
   .read_q    (read_q),
   .spi_miso  (spi_miso),
   .reg_wr    (reg_wr),
   .reg_addr  (reg_addr),
   .time_load (time_load),
   .time_wmask(time_wmask)
);

// File: tb/spi_regs_slave_tb.sv
`timescale 1ns/1ps
module spi_regs_slave_tb;

   localparam int HALF = 10;   // system clocks per serial half period

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        spi_cs = 1'b0, spi_sclk = 1'b0, spi_mosi = 1'b0;
   logic        spi_miso;
   logic [3:0]  reg_addr;
   logic [7:0]  reg_wdata, reg_rdata;
   logic        reg_wr;
   logic [55:0] time_in = '0;
   logic        time_load;
   logic [55:0] time_wdata;
   logic [6:0]  time_wmask;

   always #10 clk = ~clk;   // 50 MHz

   spi_regs_slave u_dut (
      .clk(clk), .rst_n(rst_n),
      .spi_cs(spi_cs), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_wr(reg_wr), .reg_rdata(reg_rdata),
      .time_in(time_in), .time_load(time_load), .time_wdata(time_wdata), .time_wmask(time_wmask)
   );

   // bench model of the upper register file
   logic [7:0] ext [16];
   int         wr_cnt = 0;
   assign reg_rdata = ext[reg_addr];
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 16; i++) ext[i] <= 8'hA0 + 8'(i);
      end else if (reg_wr) begin
         ext[reg_addr] <= reg_wdata;
         wr_cnt = wr_cnt + 1;
      end
   end

   // load pulse monitor
   int          load_cnt = 0;
   logic [55:0] load_data_cap = '0;
   logic [6:0]  load_mask_cap = '0;
   always @(posedge clk) begin
      if (rst_n && time_load) begin
         load_cnt      = load_cnt + 1;
         load_data_cap = time_wdata;
         load_mask_cap = time_wmask;
      end
   end

   int checks = 0, fails = 0;
   logic [7:0] txb [8];
   logic [7:0] rxb [8];
   logic [7:0] got;

   task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic cs_on();
      @(negedge clk); spi_cs = 1'b1;
      repeat (6) @(negedge clk);
   endtask

   task automatic cs_off();
      @(negedge clk); spi_cs = 1'b0; spi_sclk = 1'b0;
      repeat (10) @(negedge clk);
   endtask

   // master: drive on rising edge, sample MISO just before the falling edge
   task automatic spi_bits(input logic [7:0] tx, input int nb);
      got = '0;
      for (int i = 7; i >= 8 - nb; i--) begin
         @(negedge clk); spi_sclk = 1'b1; spi_mosi = tx[i];
         repeat (HALF) @(negedge clk);
         got[i] = spi_miso;
         spi_sclk = 1'b0;
         repeat (HALF - 1) @(negedge clk);
      end
   endtask

   task automatic xfer(input int n);
      cs_on();
      for (int k = 0; k < n; k++) begin
         spi_bits(txb[k], 8);
         rxb[k] = got;
      end
      cs_off();
   endtask

   // table: {address, data} for single write then single read back
   localparam logic [11:0] VEC [6] = '{
      {4'd7,  8'h5A}, {4'd9,  8'hC3}, {4'd15, 8'hFF},
      {4'd12, 8'h00}, {4'd8,  8'h81}, {4'd13, 8'hFE}
   };

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      int w0, l0;
      repeat (3) @(negedge clk);
      // R10 reset state
      chk("R10", "miso in reset", 64'(spi_miso), 64'h0);
      chk("R10", "reg_wr in reset", 64'(reg_wr), 64'h0);
      chk("R10", "time_load in reset", 64'(time_load), 64'h0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      // table walk: R1 R2 R3 R5
      for (int v = 0; v < 6; v++) begin
         w0 = wr_cnt;
         txb[0] = {VEC[v][11:8], 4'h8}; txb[1] = VEC[v][7:0];
         xfer(2);
         chk("R5", "one strobe per single write", 64'(wr_cnt - w0), 64'd1);
         chk("R5", "register file content", 64'(ext[VEC[v][11:8]]), 64'(VEC[v][7:0]));
         txb[0] = {VEC[v][11:8], 4'hC}; txb[1] = 8'h00;
         xfer(2);
         chk("R2", "single read MSB first", 64'(rxb[1]), 64'(VEC[v][7:0]));
      end

      // R6 snapshot: change time_in right after the command byte
      for (int k = 0; k < 7; k++) time_in[k*8 +: 8] = 8'h10 + 8'(k);
      cs_on();
      spi_bits(8'h04, 8);
      time_in = {7{8'hEE}};
      for (int k = 1; k < 8; k++) begin spi_bits(8'h00, 8); rxb[k] = got; end
      cs_off();
      for (int k = 1; k < 8; k++)
         chk("R6", $sformatf("burst read snapshot byte %0d", k - 1), 64'(rxb[k]), 64'(8'h10 + 8'(k - 1)));
      txb[0] = 8'h0C; txb[1] = 8'h00;
      xfer(2);
      chk("R6", "new window takes new snapshot", 64'(rxb[1]), 64'hEE);

      // R7 burst write of all time registers; R9 MISO quiet during write
      l0 = load_cnt; w0 = wr_cnt;
      cs_on();
      spi_bits(8'h00, 8); rxb[0] = got;
      for (int k = 1; k < 8; k++) begin spi_bits(8'h20 + 8'(k), 8); rxb[k] = got; end
      repeat (5) @(negedge clk);
      chk("R7", "no load while selected", 64'(load_cnt - l0), 64'd0);
      cs_off();
      chk("R7", "one load after release", 64'(load_cnt - l0), 64'd1);
      chk("R7", "load mask", 64'(load_mask_cap), 64'h7F);
      chk("R7", "load data", 64'(load_data_cap), 64'h27_26_25_24_23_22_21);
      chk("R7", "no register file strobes", 64'(wr_cnt - w0), 64'd0);
      chk("R9", "miso low during write",
          64'(rxb[0] | rxb[1] | rxb[2] | rxb[3] | rxb[4] | rxb[5] | rxb[6] | rxb[7]), 64'h0);
      chk("R9", "miso low when idle", 64'(spi_miso), 64'h0);

      // R4 burst write wraps 15 -> 0
      l0 = load_cnt;
      txb[0] = 8'hE0; txb[1] = 8'h41; txb[2] = 8'h42; txb[3] = 8'h43;
      xfer(4);
      chk("R4", "wrap write addr 14", 64'(ext[14]), 64'h41);
      chk("R4", "wrap write addr 15", 64'(ext[15]), 64'h42);
      chk("R4", "wrap write mask addr 0", 64'(load_mask_cap), 64'h01);
      chk("R4", "wrap write data addr 0", 64'(load_data_cap[7:0]), 64'h43);

      // R4 burst read across time/file boundary (time_in snapshot = EE)
      txb[0] = 8'h54; for (int k = 1; k < 5; k++) txb[k] = 8'h00;
      xfer(5);
      chk("R4", "boundary read addr 5", 64'(rxb[1]), 64'hEE);
      chk("R4", "boundary read addr 6", 64'(rxb[2]), 64'hEE);
      chk("R4", "boundary read addr 7", 64'(rxb[3]), 64'(ext[7]));
      chk("R4", "boundary read addr 8", 64'(rxb[4]), 64'(ext[8]));
      txb[0] = 8'hF4; txb[1] = 8'h00; txb[2] = 8'h00;
      xfer(3);
      chk("R4", "read wrap addr 15", 64'(rxb[1]), 64'h42);
      chk("R4", "read wrap addr 0", 64'(rxb[2]), 64'hEE);

      // R3 extra bytes after a single access
      w0 = wr_cnt;
      txb[0] = 8'hA8; txb[1] = 8'h11; txb[2] = 8'h22;
      xfer(3);
      chk("R3", "single write first byte", 64'(ext[10]), 64'h11);
      chk("R3", "single write no second strobe", 64'(wr_cnt - w0), 64'd1);
      chk("R3", "neighbour untouched", 64'(ext[11]), 64'hAB);
      txb[0] = 8'hAC; txb[1] = 8'h00; txb[2] = 8'h00;
      xfer(3);
      chk("R3", "single read first byte", 64'(rxb[1]), 64'h11);
      chk("R3", "single read surplus byte", 64'(rxb[2]), 64'h00);

      // R8 abort mid data byte, then mid command byte
      w0 = wr_cnt;
      cs_on(); spi_bits(8'h98, 8); spi_bits(8'h55, 4); cs_off();
      chk("R8", "aborted byte not written", 64'(wr_cnt - w0), 64'd0);
      chk("R8", "register keeps value", 64'(ext[9]), 64'hC3);
      cs_on(); spi_bits(8'hB8, 5); cs_off();
      txb[0] = 8'h98; txb[1] = 8'h77;
      xfer(2);
      chk("R8", "next window restarts at command", 64'(ext[9]), 64'h77);

      // R1 low command bits are ignored: 0x7B acts as single write to 7
      txb[0] = 8'h7B; txb[1] = 8'h3C; txb[2] = 8'h99;
      xfer(3);
      chk("R1", "don't-care bits single write", 64'(ext[7]), 64'h3C);
      chk("R1", "don't-care bits single kept", 64'(ext[8]), 64'h81);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule